// File: doc/BRIEF.md
# Gen2 Stuck-Link Recovery Monitor

This block answers a link-status query for a PCIe root port. When `check_req` is pulsed, it looks at two PHY debug words that it receives as plain inputs. If the training flag is still set, it reports the link as down and does nothing else. If the flag is clear, it reads the PHY receive-valid register through an indirect register-access port. When the LTSSM state field shows the receiver-lock recovery state and receive-valid is low, it treats the upgrade to the higher link speed as stuck and starts a recovery.

Recovery is a timed pulse on two receiver override bits in a PHY register. The block reads the register, writes it back with both bits set, waits a programmable number of clock cycles (about 2 ms in use), reads it again and writes it back with both bits cleared. Each successful recovery raises a flag and increments a counter. A timeout on the access port stops the sequence and raises an error flag. If an override write may already have landed, the block makes one final clearing write first.

Top module: `gen2_rcvr_watch`

## Requirements
- R1: When `check_req` is accepted while idle and bit 4 of `dbg_word1` (the training flag) is 1, `link_up` becomes 0 on the next cycle, `busy` stays 0 and no PHY access is issued.
- R2: With the training flag clear, the block reads PHY address 0x100D. If bit 0 of the returned data (receive valid) is 1, it ends the check with `link_up` = 1 after that single access.
- R3: The LTSSM state is bits 5:0 of `dbg_word0`, and higher bits are ignored. When receive valid is 0 and the state differs from 0x0D, the check ends with `link_up` = 1 after one access.
- R4: When receive valid is 0 and the state is 0x0D, the block reads PHY address 0x1005 and writes back the returned value with bits 5 and 3 (mask 0x0028) set and every other bit preserved.
- R5: After the setting write completes, no further PHY access starts for at least `HOLD_CYC` clock cycles.
- R6: After the hold, the block reads 0x1005 again and writes back that value with bits 5 and 3 cleared. It then ends with `link_up` = 0 and `recovered` = 1, and `recov_count` increments by one and wraps at its width.
- R7: `acc_req` stays high with address, direction and write data stable until `acc_done` or `acc_timeout`. It is low for at least one cycle after each completion. Writes go only to address 0x1005.
- R8: A timeout on the receive-valid read or on the first 0x1005 read ends the check with `err` = 1, `link_up` = 0 and no write issued.
- R9: A timeout on the setting write or on the second read causes exactly one clearing write of the first-read value with mask 0x0028 cleared. A timeout on the clearing write causes no retry. In all these cases the check ends with `err` = 1 and `recovered` = 0, and the counter does not change.
- R10: `busy` is high from the cycle after an accepted check that needs PHY access until the result is posted. A `check_req` seen while `busy` is ignored. `recovered` and `err` are cleared when a check is accepted.
- R11: After reset, `link_up`, `busy`, `recovered`, `err`, `acc_req` and `recov_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| check_req | input | 1 | Pulse asking for a link-status check |
| dbg_word0 | input | 32 | PHY debug word 0; bits 5:0 hold the LTSSM state |
| dbg_word1 | input | 32 | PHY debug word 1; bit 4 is the training flag |
| acc_req | output | 1 | PHY register access request |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 16 | PHY register address |
| acc_wdata | output | 16 | PHY write data |
| acc_rdata | input | 16 | PHY read data, valid with `acc_done` |
| acc_done | input | 1 | One-cycle access completion |
| acc_timeout | input | 1 | One-cycle access failure |
| link_up | output | 1 | Result of the last check |
| busy | output | 1 | Check in progress |
| recovered | output | 1 | Last check ran a full recovery |
| err | output | 1 | Last check was cut short by an access timeout |
| recov_count | output | CNT_W | Number of completed recoveries |

## Verification
The assertions assume the access port behaves as a simple handshake. `acc_done` and `acc_timeout` are single-cycle pulses that never arrive together, and they only come while `acc_req` is high. They also assume the debug words do not change while a check is running. The bench's responder model completes each access one negedge at a time after a latency of 0 to 2 cycles, and it changes the debug words only between checks. Timeouts are injected only at chosen access positions, always in place of a completion.

// File: rtl/gen2_rcvr_watch.sv
module gen2_rcvr_watch #(
  parameter int HOLD_CYC = 100000,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_req,
  input  logic [31:0]      dbg_word0,
  input  logic [31:0]      dbg_word1,
  output logic             acc_req,
  output logic             acc_wr,
  output logic [15:0]      acc_addr,
  output logic [15:0]      acc_wdata,
  input  logic [15:0]      acc_rdata,
  input  logic             acc_done,
  input  logic             acc_timeout,
  output logic             link_up,
  output logic             busy,
  output logic             recovered,
  output logic             err,
  output logic [CNT_W-1:0] recov_count
);
  localparam int          HC_W      = $clog2(HOLD_CYC + 1);
  localparam logic [15:0] VLD_ADDR  = 16'h100D;
  localparam logic [15:0] OVR_ADDR  = 16'h1005;
  localparam logic [15:0] OVR_MASK  = 16'h0028;
  localparam logic [5:0]  STUCK_ST  = 6'h0D;
  localparam int          TRAIN_BIT = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_VLD, S_RD_OVR, S_WR_SET, S_HOLD, S_RD_OVR2, S_WR_CLR
  } st_t;

  st_t             st;
  logic            gap, abort_q;
  logic [15:0]     ovr_q;
  logic [HC_W-1:0] hc;
  logic            ev;

  assign busy      = (st != S_IDLE);
  assign acc_req   = busy && (st != S_HOLD) && !gap;
  assign acc_wr    = (st == S_WR_SET) || (st == S_WR_CLR);
  assign acc_addr  = (st == S_RD_VLD) ? VLD_ADDR : OVR_ADDR;
  assign acc_wdata = (st == S_WR_SET) ? (ovr_q | OVR_MASK) :
                     (st == S_WR_CLR) ? (ovr_q & ~OVR_MASK) : 16'h0000;
  assign ev        = acc_req && (acc_done || acc_timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      gap         <= 1'b0;
      abort_q     <= 1'b0;
      ovr_q       <= '0;
      hc          <= '0;
      link_up     <= 1'b0;
      recovered   <= 1'b0;
      err         <= 1'b0;
      recov_count <= '0;
    end else begin
      gap <= ev;
      unique case (st)
        S_IDLE: if (check_req) begin
          recovered <= 1'b0;
          err       <= 1'b0;
          if (dbg_word1[TRAIN_BIT]) link_up <= 1'b0;
          else                      st      <= S_RD_VLD;
        end
        S_RD_VLD: if (ev) begin
          if (acc_timeout) begin
            err     <= 1'b1;
            link_up <= 1'b0;
            st      <= S_IDLE;
          end else if (acc_rdata[0] || dbg_word0[5:0] != STUCK_ST) begin
            link_up <= 1'b1;
            st      <= S_IDLE;
          end else begin
            st <= S_RD_OVR;
          end
        end
        S_RD_OVR: if (ev) begin
          if (acc_timeout) begin
            err     <= 1'b1;
            link_up <= 1'b0;
            st      <= S_IDLE;
          end else begin
            ovr_q <= acc_rdata;
            st    <= S_WR_SET;
          end
        end
        S_WR_SET: if (ev) begin
          if (acc_timeout) begin
            abort_q <= 1'b1;
            st      <= S_WR_CLR;
          end else begin
            hc <= HC_W'(HOLD_CYC - 1);
            st <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (hc == '0) st <= S_RD_OVR2;
          else          hc <= hc - 1'b1;
        end
        S_RD_OVR2: if (ev) begin
          if (acc_timeout) abort_q <= 1'b1;
          else             ovr_q   <= acc_rdata;
          st <= S_WR_CLR;
        end
        S_WR_CLR: if (ev) begin
          link_up <= 1'b0;
          abort_q <= 1'b0;
          st      <= S_IDLE;
          if (acc_timeout || abort_q) begin
            err <= 1'b1;
          end else begin
            recovered   <= 1'b1;
            recov_count <= recov_count + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module gen2_rcvr_watch_chk #(
  parameter int HOLD_CYC = 100000,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             check_req,
  input logic [31:0]      dbg_word1,
  input logic             acc_req,
  input logic             acc_wr,
  input logic [15:0]      acc_addr,
  input logic [15:0]      acc_wdata,
  input logic             acc_done,
  input logic             acc_timeout,
  input logic             link_up,
  input logic             busy,
  input logic             recovered,
  input logic             err,
  input logic [CNT_W-1:0] recov_count
);
  logic        armed;
  logic [31:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      since <= '0;
    end else if (acc_req && acc_done && acc_wr && (acc_wdata & 16'h0028) == 16'h0028) begin
      armed <= 1'b1;
      since <= '0;
    end else if (acc_req && acc_done && acc_wr) begin
      armed <= 1'b0;
    end else if (armed && since != 32'hFFFF_FFFF) begin
      since <= since + 1;
    end
  end

  AST_TRAIN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    check_req && !busy && dbg_word1[4] |=> !busy && !link_up); // R1
  AST_WRITE_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_wr |-> acc_addr == 16'h1005); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_done && !acc_timeout |=>
      acc_req && $stable(acc_addr) && $stable(acc_wr) && $stable(acc_wdata)); // R7
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && (acc_done || acc_timeout) |=> !acc_req); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !acc_req); // R10
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_req) && armed |-> since >= HOLD_CYC); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovered) |-> recov_count == $past(recov_count) + 1'b1 && !link_up); // R6
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && recovered)); // R9
endmodule

bind gen2_rcvr_watch gen2_rcvr_watch_chk #(.HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .check_req(check_req), .dbg_word1(dbg_word1),
  .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .acc_done(acc_done), .acc_timeout(acc_timeout), .link_up(link_up), .busy(busy),
  .recovered(recovered), .err(err), .recov_count(recov_count)
);

// File: tb/gen2_rcvr_watch_bench.sv
module gen2_rcvr_watch_bench;
  localparam int HOLD = 20;
  localparam int CW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          check_req = 1'b0;
  logic [31:0]   dbg_word0 = '0, dbg_word1 = '0;
  logic          acc_req, acc_wr;
  logic [15:0]   acc_addr, acc_wdata;
  logic [15:0]   acc_rdata = '0;
  logic          acc_done = 1'b0, acc_timeout = 1'b0;
  logic          link_up, busy, recovered, err;
  logic [CW-1:0] recov_count;

  always #10 clk = ~clk;

  gen2_rcvr_watch #(.HOLD_CYC(HOLD), .CNT_W(CW)) u_gen2_rcvr_watch (
    .clk(clk), .rst_n(rst_n), .check_req(check_req),
    .dbg_word0(dbg_word0), .dbg_word1(dbg_word1),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_done(acc_done), .acc_timeout(acc_timeout),
    .link_up(link_up), .busy(busy), .recovered(recovered), .err(err),
    .recov_count(recov_count)
  );

  // responder model of the PHY access port
  int          vec_id = 0, seen_id = 0;
  logic [15:0] ovr_init = '0, rxv = '0, ovr_reg = '0, wr_first = '0;
  int          to_idx = 0, acc_n = 0, nw = 0, wait_n = 0, ncnt = 0;
  int          set_at = 0, min_hold = 1000000;
  bit          active = 0, hold_armed = 0, gap_bad = 0;

  always @(negedge clk) begin
    ncnt = ncnt + 1;
    if (vec_id != seen_id) begin
      seen_id = vec_id; ovr_reg = ovr_init; acc_n = 0; nw = 0; wr_first = '0;
    end
    if (acc_done || acc_timeout) begin
      acc_done = 1'b0; acc_timeout = 1'b0;
      if (acc_req) gap_bad = 1;
    end else if (active) begin
      if (wait_n == 0) begin
        active = 0;
        if (acc_n == to_idx) acc_timeout = 1'b1;
        else begin
          acc_done = 1'b1;
          if (acc_wr) begin
            ovr_reg = acc_wdata;
            if (nw == 0) wr_first = acc_wdata;
            nw = nw + 1;
            if ((acc_wdata & 16'h0028) == 16'h0028) begin hold_armed = 1; set_at = ncnt; end
          end else acc_rdata = (acc_addr == 16'h100D) ? rxv : ovr_reg;
        end
      end else wait_n = wait_n - 1;
    end else if (acc_req) begin
      active = 1; acc_n = acc_n + 1; wait_n = acc_n % 3;
      if (hold_armed) begin
        hold_armed = 0;
        if (ncnt - set_at < min_hold) min_hold = ncnt - set_at;
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // d0, d1, rxv, init, to, link, rec, err, final, nacc
  localparam int VW = 32 + 32 + 16 + 16 + 3 + 1 + 1 + 1 + 16 + 3;
  localparam logic [VW-1:0] VEC [0:11] = '{
    {32'h0000000D, 32'h00000010, 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 3'd0},
    {32'h0000000D, 32'h00000000, 16'h0001, 16'h00FF, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00FF, 3'd1},
    {32'h00000011, 32'hFFFFFFEF, 16'hFFFE, 16'h5555, 3'd0, 1'b1, 1'b0, 1'b0, 16'h5555, 3'd1},
    {32'h0000000D, 32'h00000000, 16'h0000, 16'h1234, 3'd0, 1'b0, 1'b1, 1'b0, 16'h1214, 3'd5},
    {32'hFFFFFFCD, 32'h00000000, 16'hFFFE, 16'hFFFF, 3'd0, 1'b0, 1'b1, 1'b0, 16'hFFD7, 3'd5},
    {32'h0000000D, 32'h00000000, 16'h0000, 16'h0F0F, 3'd1, 1'b0, 1'b0, 1'b1, 16'h0F0F, 3'd1},
    {32'h0000000D, 32'h00000000, 16'h0000, 16'h0F0F, 3'd2, 1'b0, 1'b0, 1'b1, 16'h0F0F, 3'd2},
    {32'h0000000D, 32'h00000000, 16'h0000, 16'h00A8, 3'd3, 1'b0, 1'b0, 1'b1, 16'h0080, 3'd4},
    {32'h0000000D, 32'h00000000, 16'h0000, 16'h0008, 3'd4, 1'b0, 1'b0, 1'b1, 16'h0000, 3'd5},
    {32'h0000000D, 32'h00000000, 16'h0000, 16'h1200, 3'd5, 1'b0, 1'b0, 1'b1, 16'h1228, 3'd5},
    {32'h0000004D, 32'hFFFFFFEF, 16'h0002, 16'h0100, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0100, 3'd5},
    {32'h0000000C, 32'h00000000, 16'h0000, 16'h0042, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0042, 3'd1}
  };

  logic [CW-1:0] exp_cnt = '0;

  task automatic run_check(input logic [31:0] d0, input logic [31:0] d1, input logic [15:0] rv,
                           input logic [15:0] init, input int to, input bit mid_pulse);
    @(negedge clk);
    dbg_word0 = d0; dbg_word1 = d1; rxv = rv; ovr_init = init; to_idx = to;
    vec_id = vec_id + 1;
    @(negedge clk);
    check_req = 1'b1;
    @(negedge clk);
    check_req = 1'b0;
    if (mid_pulse) begin
      repeat (12) @(negedge clk);
      check_req = 1'b1;
      @(negedge clk);
      check_req = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 link_up", link_up, 0);
    chk("R11 busy", busy, 0);
    chk("R11 recovered", recovered, 0);
    chk("R11 err", err, 0);
    chk("R11 acc_req", acc_req, 0);
    chk("R11 recov_count", recov_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [31:0] d0, d1;
      logic [15:0] rv, init, fin;
      logic [2:0]  to, nacc;
      logic        el, er, ee;
      {d0, d1, rv, init, to, el, er, ee, fin, nacc} = VEC[i];
      run_check(d0, d1, rv, init, int'(to), 1'b0);
      if (er) exp_cnt = exp_cnt + 1'b1;
      chk("R1/R2/R3/R6 link_up", link_up, el);
      chk("R6 recovered", recovered, er);
      chk("R8/R9 err", err, ee);
      chk("R4/R6/R9 final override reg", ovr_reg, fin);
      chk("R1/R2/R3/R8 access count", acc_n, nacc);
      chk("R6/R9 recov_count", recov_count, exp_cnt);
      if (er) chk("R4 setting write value", wr_first, init | 16'h0028);
    end

    // R10: second request during recovery is ignored
    run_check(32'h0000000D, 32'h0, 16'h0000, 16'h0040, 0, 1'b1);
    exp_cnt = exp_cnt + 1'b1;
    chk("R10 ignored request access count", acc_n, 5);
    chk("R10 ignored request count", recov_count, exp_cnt);
    chk("R10 ignored request final reg", ovr_reg, 16'h0040);
    // R10: new check clears stale flags; training flag case
    run_check(32'h0000000D, 32'h00000010, 16'h0000, 16'h0000, 0, 1'b0);
    chk("R10 recovered cleared", recovered, 0);
    chk("R1 no access when training", acc_n, 0);
    // R5 hold window and R7 gap
    chk("R5 hold window", (min_hold >= HOLD), 1);
    chk("R7 request gap", gap_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule